// File: doc/BRIEF.md
# Chip-Grouped 16-bit Hit Formatter

This block gathers the hits that belong to one flex cable and re-emits them as a compact stream of 16-bit words. The words carry little context of their own; the context lives in headers. Each cable produces three header words first: the event number, the cable number and the total hit count. After that, every run of hits from the same chip is preceded by a single chip header. The chip header gives the pipeline cell and the chip number. The hit words that follow it hold only the error flag, channel, range bit and ADC value.

A cable is opened with a start transfer that carries the event and cable numbers. Its hits then arrive one per cycle on a valid/ready port, already sorted by chip, and a one-cycle end pulse closes the cable. The formatter must know the hit total before it can send any chip group. It therefore stores every hit of the cable in an internal buffer and begins sending only after the end pulse. The output is a valid/ready 16-bit stream. A hit whose chip number is lower than the chip of the hit before it is flagged on a separate output, and it is still sent under a chip header of its own.

Top module: `chip_grp_fmt`

## Requirements
- R1: After reset, out_valid is 0 and start_ready is 1.
- R2: A cable begins with three header words, in this order: {1, event[14:0]}, then {1, 7'b0, cable[7:0]}, then {1, hit_count[14:0]}. The count covers every hit accepted for that cable.
- R3: A chip header is {1'b1, 3'b000, cell[3:0], 4'b0000, chip[3:0]}. It comes directly before the first hit of each run of hits that share a chip number, and its cell is the cell of that first hit.
- R4: A hit word is {1'b0, err, chan[5:0], range, adc[6:0]}. Hit words appear in the order the hits were accepted.
- R5: Consecutive hits from the same chip share one chip header, and a chip that has no hits gets no header.
- R6: While hits are being collected, out_valid stays 0. Output begins in the cycle after the end pulse is taken.
- R7: A cable with no hits produces only the three header words, with a count of 0, and then returns to idle.
- R8: order_err is high for exactly one cycle, the cycle after a hit is accepted whose chip number is lower than that of the previous hit in the same cable. It is 0 at all other times. That hit opens a fresh chip header.
- R9: While out_valid is 1 and out_ready is 0, out_data and out_valid hold their values into the next cycle.
- R10: Once DEPTH hits of a cable have been accepted, hit_ready stays 0 until the cable is closed.
- R11: start_ready is 1 only while idle, hit_ready is 1 only while collecting, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Opens a cable |
| start_ready | output | 1 | High when idle, so a new cable can be opened |
| start_event | input | 15 | Event number of the cable |
| start_cable | input | 8 | Cable number |
| hit_valid | input | 1 | Hit offered |
| hit_ready | output | 1 | Hit accepted on this cycle if hit_valid is high |
| hit_chip | input | 4 | Chip number of the hit |
| hit_cell | input | 4 | Pipeline cell of the hit |
| hit_chan | input | 6 | Channel within the chip |
| hit_range | input | 1 | ADC range bit |
| hit_adc | input | 7 | ADC value |
| hit_err | input | 1 | Error flag of the hit |
| cab_end | input | 1 | Closes collection; taken only while collecting |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 16 | Output word |
| order_err | output | 1 | One-cycle pulse for a hit with a lower chip number than the previous hit |

## Verification
Internal faults tend to show up as a wrong output word, not as a hang. If the stored chip run boundary is wrong, a chip header goes missing or is repeated, so the word count and the word positions shift at the very next chip change. A read pointer that advances at the wrong time repeats or skips a hit word, and this shows in the same cable. A wrong collection counter shows in the third header word as soon as output begins. A wrong state transition shows as out_valid rising during collection, or as a cable that never returns to idle; the bench reports the first as a word mismatch and the second through the word count. The previous-chip tracker is checked through the number of order_err pulses counted in each cable.

// File: rtl/chip_grp_fmt.sv
module chip_grp_fmt #(
  parameter int DEPTH = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_valid,
  output logic        start_ready,
  input  logic [14:0] start_event,
  input  logic [7:0]  start_cable,
  input  logic        hit_valid,
  output logic        hit_ready,
  input  logic [3:0]  hit_chip,
  input  logic [3:0]  hit_cell,
  input  logic [5:0]  hit_chan,
  input  logic        hit_range,
  input  logic [6:0]  hit_adc,
  input  logic        hit_err,
  input  logic        cab_end,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [15:0] out_data,
  output logic        order_err
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_COLL, S_EVT, S_CAB, S_CNT, S_BODY} st_t;
  st_t st;

  logic [22:0]   mem [DEPTH];
  logic [CW-1:0] cnt, rd;
  logic [14:0]   ev_q;
  logic [7:0]    cab_q;
  logic [3:0]    in_chip, cur_chip;
  logic          in_have, cur_have;

  wire take_start = start_valid && start_ready;
  wire take_hit   = hit_valid && hit_ready;
  wire xfer       = out_valid && out_ready;

  assign start_ready = (st == S_IDLE);
  assign hit_ready   = (st == S_COLL) && (cnt != CW'(DEPTH));
  assign out_valid   = (st == S_EVT) || (st == S_CAB) || (st == S_CNT) || (st == S_BODY);

  wire [22:0] ent      = mem[rd[AW-1:0]];
  wire [3:0]  e_chip   = ent[22:19];
  wire [3:0]  e_cell   = ent[18:15];
  wire        new_chip = !cur_have || (e_chip != cur_chip);

  always_comb begin
    case (st)
      S_EVT:   out_data = {1'b1, ev_q};
      S_CAB:   out_data = {1'b1, 7'b0, cab_q};
      S_CNT:   out_data = {1'b1, 15'(cnt)};
      S_BODY:  out_data = new_chip ? {1'b1, 3'b000, e_cell, 4'b0000, e_chip}
                                   : {1'b0, ent[14:0]};
      default: out_data = 16'h0000;
    endcase
  end

  always_ff @(posedge clk)
    if (take_hit)
      mem[cnt[AW-1:0]] <= {hit_chip, hit_cell, hit_err, hit_chan, hit_range, hit_adc};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      rd        <= '0;
      ev_q      <= '0;
      cab_q     <= '0;
      in_chip   <= '0;
      in_have   <= 1'b0;
      cur_chip  <= '0;
      cur_have  <= 1'b0;
      order_err <= 1'b0;
    end else begin
      order_err <= take_hit && in_have && (hit_chip < in_chip);
      if (take_hit) begin
        cnt     <= cnt + CW'(1);
        in_chip <= hit_chip;
        in_have <= 1'b1;
      end
      case (st)
        S_IDLE: if (take_start) begin
          ev_q    <= start_event;
          cab_q   <= start_cable;
          cnt     <= '0;
          in_have <= 1'b0;
          st      <= S_COLL;
        end
        S_COLL: if (cab_end) st <= S_EVT;
        S_EVT:  if (xfer) st <= S_CAB;
        S_CAB:  if (xfer) st <= S_CNT;
        S_CNT:  if (xfer) begin
          rd       <= '0;
          cur_have <= 1'b0;
          st       <= (cnt == '0) ? S_IDLE : S_BODY;
        end
        S_BODY: if (xfer) begin
          if (new_chip) begin
            cur_have <= 1'b1;
            cur_chip <= e_chip;
          end else begin
            rd <= rd + CW'(1);
            if (rd + CW'(1) == cnt) st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chip_grp_fmt_chk.sv
module chip_grp_fmt_chk #(
  parameter int DEPTH = 1024
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start_valid,
  input logic        start_ready,
  input logic        hit_valid,
  input logic        hit_ready,
  input logic [3:0]  hit_chip,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_data,
  input logic        order_err
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] c_cnt;
  logic [3:0]    c_prev;
  logic          c_have;

  wire acc   = hit_valid && hit_ready;
  wire lower = acc && c_have && (hit_chip < c_prev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_cnt  <= '0;
      c_prev <= '0;
      c_have <= 1'b0;
    end else if (start_valid && start_ready) begin
      c_cnt  <= '0;
      c_have <= 1'b0;
    end else if (acc) begin
      c_cnt  <= c_cnt + CW'(1);
      c_prev <= hit_chip;
      c_have <= 1'b1;
    end
  end

  p_quiet_collect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ready |-> !out_valid);
  p_order_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lower |=> order_err);
  p_order_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lower |=> !order_err);
  p_hold_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (c_cnt == CW'(DEPTH)) |-> !hit_ready);
  p_excl_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ready && hit_ready));
endmodule

bind chip_grp_fmt chip_grp_fmt_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
  .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_chip(hit_chip),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .order_err(order_err)
);

// File: tb/chip_grp_fmt_tb.sv
`timescale 1ns/1ps
module chip_grp_fmt_tb;
  localparam int DEPTH = 1024;
  localparam int MAXW  = 1200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0;
  logic [14:0] start_event = '0;
  logic [7:0]  start_cable = '0;
  logic hit_valid = 1'b0;
  logic [3:0] hit_chip = '0, hit_cell = '0;
  logic [5:0] hit_chan = '0;
  logic hit_range = 1'b0, hit_err = 1'b0;
  logic [6:0] hit_adc = '0;
  logic cab_end = 1'b0;
  logic out_ready = 1'b1;
  logic start_ready, hit_ready, out_valid, order_err;
  logic [15:0] out_data;

  chip_grp_fmt #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_event(start_event), .start_cable(start_cable), .hit_valid(hit_valid),
    .hit_ready(hit_ready), .hit_chip(hit_chip), .hit_cell(hit_cell), .hit_chan(hit_chan),
    .hit_range(hit_range), .hit_adc(hit_adc), .hit_err(hit_err), .cab_end(cab_end),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .order_err(order_err)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int nh = 0, nc = 0, n_oerr = 0;
  bit stall = 1'b0;
  logic [3:0]  hc [MAXW];
  logic [3:0]  hl [MAXW];
  logic [5:0]  hn [MAXW];
  logic        hr [MAXW];
  logic        he [MAXW];
  logic [6:0]  ha [MAXW];
  logic [15:0] cap [MAXW];
  logic [15:0] expw [MAXW];
  logic        hold_p = 1'b0;
  logic [15:0] hold_d = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_p) check(out_valid && out_data == hold_d, "R9", int'(out_data), int'(hold_d));
      hold_p = out_valid && !out_ready;
      hold_d = out_data;
      if (out_valid && out_ready && nc < MAXW) begin
        cap[nc] = out_data;
        nc++;
      end
      if (order_err) n_oerr++;
    end
  end

  always @(posedge clk) begin
    #1 out_ready = stall ? 1'($urandom % 2) : 1'b1;
  end

  task automatic run_cable(input logic [14:0] ev, input logic [7:0] cb, input bit stl);
    int ne = 0, exp_oe = 0, n_hdr;
    bit have = 1'b0;
    logic [3:0] pc = '0;
    expw[ne++] = {1'b1, ev};
    expw[ne++] = {1'b1, 7'b0, cb};
    expw[ne++] = {1'b1, 15'(nh)};
    for (int i = 0; i < nh; i++) begin
      if (have && hc[i] < pc) exp_oe++;
      if (!have || hc[i] != pc) expw[ne++] = {1'b1, 3'b000, hl[i], 4'b0000, hc[i]};
      expw[ne++] = {1'b0, he[i], hn[i], hr[i], ha[i]};
      have = 1'b1;
      pc = hc[i];
    end
    n_hdr = ne - 3 - nh;
    nc = 0;
    n_oerr = 0;
    stall = stl;
    while (!start_ready) begin @(posedge clk); #1; end
    start_valid = 1'b1; start_event = ev; start_cable = cb;
    @(posedge clk); #1;
    start_valid = 1'b0;
    check(start_ready == 1'b0, "R11", int'(start_ready), 0);
    for (int i = 0; i < nh; i++) begin
      while (!hit_ready) begin @(posedge clk); #1; end
      hit_valid = 1'b1; hit_chip = hc[i]; hit_cell = hl[i]; hit_chan = hn[i];
      hit_range = hr[i]; hit_adc = ha[i]; hit_err = he[i];
      @(posedge clk); #1;
      hit_valid = 1'b0;
    end
    if (nh == DEPTH) check(hit_ready == 1'b0, "R10", int'(hit_ready), 0);
    check(out_valid == 1'b0 && nc == 0, "R6", int'(out_valid), 0);
    cab_end = 1'b1;
    @(posedge clk); #1;
    cab_end = 1'b0;
    check(out_valid == 1'b1 && out_data == expw[0], "R6", int'(out_data), int'(expw[0]));
    for (int t = 0; t < 20000 && nc < ne; t++) begin @(posedge clk); #1; end
    repeat (4) @(posedge clk);
    #1;
    stall = 1'b0;
    check(nc == ne, (nh == 0) ? "R7" : "R5", nc, ne);
    check(start_ready == 1'b1 && out_valid == 1'b0, (nh == 0) ? "R7" : "R11",
          int'(start_ready), 1);
    for (int i = 0; i < ne && i < nc; i++)
      check(cap[i] == expw[i], (i < 3) ? "R2" : (expw[i][15] ? "R3" : "R4"),
            int'(cap[i]), int'(expw[i]));
    check(n_oerr == exp_oe, "R8", n_oerr, exp_oe);
    if (n_hdr < 0) check(1'b0, "R3", n_hdr, 0);
  endtask

  task automatic add_hit(input int chip);
    hc[nh] = 4'(chip);
    hl[nh] = 4'($urandom);
    hn[nh] = 6'($urandom);
    hr[nh] = 1'($urandom);
    he[nh] = 1'($urandom);
    ha[nh] = 7'($urandom);
    nh++;
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    check(start_ready == 1'b1, "R1", int'(start_ready), 1);
    check(hit_ready == 1'b0, "R11", int'(hit_ready), 0);
    check(order_err == 1'b0, "R8", int'(order_err), 0);
  endtask

  task automatic t_basic();
    nh = 0;
    add_hit(0); add_hit(0); add_hit(2); add_hit(2); add_hit(2); add_hit(5);
    run_cable(15'h1234, 8'd7, 1'b0);
  endtask

  task automatic t_same_and_sparse();
    nh = 0;
    add_hit(3); add_hit(3); add_hit(3); add_hit(3);
    run_cable(15'h0001, 8'd255, 1'b0);
    nh = 0;
    add_hit(1); add_hit(7); add_hit(15); add_hit(15);
    run_cable(15'h7fff, 8'd0, 1'b0);
  endtask

  task automatic t_order();
    nh = 0;
    add_hit(4); add_hit(4); add_hit(2); add_hit(2); add_hit(9); add_hit(9); add_hit(1);
    run_cable(15'h0a0a, 8'd33, 1'b0);
  endtask

  task automatic t_stall();
    nh = 0;
    for (int i = 0; i < 40; i++) add_hit(i / 5);
    run_cable(15'h2222, 8'd128, 1'b1);
  endtask

  task automatic t_empty();
    nh = 0;
    run_cable(15'h0055, 8'd19, 1'b0);
  endtask

  task automatic t_full();
    nh = 0;
    for (int i = 0; i < DEPTH; i++) add_hit(i / 64);
    run_cable(15'h4321, 8'd200, 1'b1);
  endtask

  initial begin
    #(5.0 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    t_reset();
    t_basic();
    t_same_and_sparse();
    t_order();
    t_stall();
    t_empty();
    t_full();
    t_basic();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule